// File: doc/BRIEF.md
# Six-Control-Bit Staged ALU

A combinational 16-bit arithmetic logic unit. Two two's-complement operands pass through a fixed chain of stages. Each operand can be cleared to zero and then bitwise inverted. A single core then either adds the two conditioned operands or ANDs them bitwise. Finally the core result can be inverted. Six independent control bits drive the six stages, and nothing decodes them into an opcode.

Eighteen settings of these bits give the useful functions: constants, pass-through, bitwise complement, negation, increment, decrement, add, both subtraction orders, AND and OR. Subtraction needs no added one. Inverting one operand, adding, and then inverting the sum gives the difference. Two flags report whether the result is zero and whether it is negative.

Top module: `stage_alu`

## Requirements
- R1: When clr_x_i is 1 the x operand becomes zero. The inversion from inv_x_i is then applied to that zero, so setting both bits gives an all-ones operand whatever x_i holds.
- R2: clr_y_i and inv_y_i act on y_i in the same way and in the same order, so setting both gives an all-ones operand.
- R3: When sel_add_i is 1 the core gives the sum of the two conditioned operands. The carry out of bit 15 is dropped, so the sum wraps modulo 2^16 (0x7FFF+1 gives 0x8000).
- R4: When sel_add_i is 0 the core gives the bitwise AND of the two conditioned operands.
- R5: When inv_out_i is 1, res_o is the bitwise inverse of the core result. Otherwise res_o equals the core result.
- R6: zero_o is 1 exactly when res_o is 0x0000.
- R7: neg_o equals bit 15 of res_o, taken after the output inversion.
- R8: The control word is written {clr_x, inv_x, clr_y, inv_y, sel_add, inv_out}, MSB first. It gives these results: 101010 gives 0, 111111 gives 1 and 111010 gives -1. 001100 gives x, 110000 gives y, 001101 gives ~x and 110001 gives ~y. 001111 gives -x, 110011 gives -y, 011111 gives x+1, 110111 gives y+1, 001110 gives x-1 and 110010 gives y-1. 000010 gives x+y, 010011 gives x-y, 000111 gives y-x, 000000 gives x&y and 010101 gives x|y.
- R9: Control words outside that list follow the stage chain with no special handling. For example, 000001 gives ~(x&y), 000011 gives ~(x+y) and 100001 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 16 | First operand, two's complement |
| y_i | input | 16 | Second operand, two's complement |
| clr_x_i | input | 1 | Clear x before its inversion stage |
| inv_x_i | input | 1 | Invert the (possibly cleared) x |
| clr_y_i | input | 1 | Clear y before its inversion stage |
| inv_y_i | input | 1 | Invert the (possibly cleared) y |
| sel_add_i | input | 1 | Core select: 1 add, 0 bitwise AND |
| inv_out_i | input | 1 | Invert the core result |
| res_o | output | 16 | Result |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result is negative |

## Verification
The bound checker watches the internal stage boundaries whenever an input changes. It checks that a cleared and inverted operand is all ones, and that an AND result never holds a bit the conditioned x lacks. It also checks that adding a zero operand passes the other one through, that the output inversion mirrors the core, and that the two flags stay consistent with the result. Only the bench's scenarios can show the arithmetic meaning of the eighteen settings, the wrap at the 16-bit boundary, and the exact values of unlisted control words, because these need reference values computed from the operands.

// File: rtl/stage_alu_pkg.sv
package stage_alu_pkg;
  // per-operand conditioning: clear first, then invert
  typedef struct packed {
    logic clr;
    logic inv;
  } opnd_ctl_t;
endpackage

// File: rtl/stage_alu_prep.sv
module stage_alu_prep
  import stage_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  opnd_ctl_t      ctl_i,
  input  logic [W-1:0]   d_i,
  output logic [W-1:0]   d_o
);
  logic [W-1:0] zeroed;

  always_comb begin
    zeroed = ctl_i.clr ? '0 : d_i;
    d_o    = ctl_i.inv ? ~zeroed : zeroed;
  end
endmodule

// File: rtl/stage_alu_core.sv
module stage_alu_core #(
  parameter int W      = 16,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_add_i,
  output logic [W-1:0] core_o
);
  logic [W-1:0] sum;

  generate
    if (RIPPLE) begin : g_ripple
      logic [W-1:0] cy;
      assign cy[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = a_i[i] ^ b_i[i] ^ cy[i];
        // carry out of the top bit is not built: sum wraps
        if (i < W-1) begin : g_cy
          assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
        end
      end
    end else begin : g_flat
      assign sum = a_i + b_i;
    end
  endgenerate

  assign core_o = sel_add_i ? sum : (a_i & b_i);
endmodule

// File: rtl/stage_alu_post.sv
module stage_alu_post #(
  parameter int W = 16
) (
  input  logic [W-1:0] core_i,
  input  logic         inv_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         neg_o
);
  always_comb begin
    res_o  = inv_i ? ~core_i : core_i;
    zero_o = ~|res_o;
    neg_o  = res_o[W-1];
  end
endmodule

// File: rtl/stage_alu.sv
module stage_alu
  import stage_alu_pkg::*;
#(
  parameter int W      = 16,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         clr_x_i,
  input  logic         inv_x_i,
  input  logic         clr_y_i,
  input  logic         inv_y_i,
  input  logic         sel_add_i,
  input  logic         inv_out_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         neg_o
);
  opnd_ctl_t    ctl_x, ctl_y;
  logic [W-1:0] x_pre, y_pre, core;

  assign ctl_x = '{clr: clr_x_i, inv: inv_x_i};
  assign ctl_y = '{clr: clr_y_i, inv: inv_y_i};

  stage_alu_prep #(.W(W)) u_prep_x (.ctl_i(ctl_x), .d_i(x_i), .d_o(x_pre));
  stage_alu_prep #(.W(W)) u_prep_y (.ctl_i(ctl_y), .d_i(y_i), .d_o(y_pre));

  stage_alu_core #(.W(W), .RIPPLE(RIPPLE)) u_core (
    .a_i(x_pre), .b_i(y_pre), .sel_add_i(sel_add_i), .core_o(core)
  );

  stage_alu_post #(.W(W)) u_post (
    .core_i(core), .inv_i(inv_out_i), .res_o(res_o), .zero_o(zero_o), .neg_o(neg_o)
  );
endmodule

// File: rtl/stage_alu_chk.sv
module stage_alu_chk #(
  parameter int W = 16
) (
  input logic         clr_x_i,
  input logic         inv_x_i,
  input logic         clr_y_i,
  input logic         inv_y_i,
  input logic         sel_add_i,
  input logic         inv_out_i,
  input logic [W-1:0] x_pre_i,
  input logic [W-1:0] y_pre_i,
  input logic [W-1:0] core_i,
  input logic [W-1:0] res_i,
  input logic         zero_i,
  input logic         neg_i
);
  always_comb begin
    p_clr_inv_x_r1: assert (!(clr_x_i && inv_x_i) || (x_pre_i == '1))
      else $error("x clear/invert order broken");
    p_clr_only_x_r1: assert (!(clr_x_i && !inv_x_i) || (x_pre_i == '0))
      else $error("x clear failed");
    p_clr_inv_y_r2: assert (!(clr_y_i && inv_y_i) || (y_pre_i == '1))
      else $error("y clear/invert order broken");
    p_add_zero_r3: assert (!(sel_add_i && x_pre_i == '0) || (core_i == y_pre_i))
      else $error("add with zero operand wrong");
    p_and_subset_r4: assert (sel_add_i || ((core_i & ~x_pre_i) == '0))
      else $error("AND result holds bit absent in x");
    p_post_inv_r5: assert ((res_i ^ core_i) == {W{inv_out_i}})
      else $error("output inversion mismatch");
    p_zero_neg_r6: assert (!(zero_i && neg_i))
      else $error("zero and negative both set");
    p_neg_msb_r7: assert (neg_i == (res_i >= (W'(1) << (W-1))))
      else $error("negative flag disagrees with result");
  end
endmodule

bind stage_alu stage_alu_chk #(.W(W)) u_chk (
  .clr_x_i(clr_x_i), .inv_x_i(inv_x_i), .clr_y_i(clr_y_i), .inv_y_i(inv_y_i),
  .sel_add_i(sel_add_i), .inv_out_i(inv_out_i),
  .x_pre_i(x_pre), .y_pre_i(y_pre), .core_i(core),
  .res_i(res_o), .zero_i(zero_o), .neg_i(neg_o)
);

// File: tb/stage_alu_tb.sv
module stage_alu_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] x, y, res;
  logic [5:0]  ctl;
  logic        zero, neg;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10ns clk = ~clk;

  stage_alu u_dut (
    .x_i(x), .y_i(y),
    .clr_x_i(ctl[5]), .inv_x_i(ctl[4]), .clr_y_i(ctl[3]), .inv_y_i(ctl[2]),
    .sel_add_i(ctl[1]), .inv_out_i(ctl[0]),
    .res_o(res), .zero_o(zero), .neg_o(neg)
  );

  localparam logic [5:0] CODES [18] = '{
    6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
    6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
    6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101};

  function automatic logic [15:0] f_expect(input int k, input logic [15:0] a, input logic [15:0] b);
    case (k)
      0: return 16'h0000;   1: return 16'h0001;   2: return 16'hFFFF;
      3: return a;          4: return b;          5: return ~a;
      6: return ~b;         7: return -a;         8: return -b;
      9: return a + 16'd1;  10: return b + 16'd1; 11: return a - 16'd1;
      12: return b - 16'd1; 13: return a + b;     14: return a - b;
      15: return b - a;     16: return a & b;     default: return a | b;
    endcase
  endfunction

  // drive at negedge, sample mid low phase
  task automatic apply(input logic [5:0] c, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    ctl = c; x = a; y = b;
    #5ns;
  endtask

  task automatic check(input string tag, input logic [15:0] exp);
    n_chk++;
    if (res !== exp || zero !== (exp == 16'h0) || neg !== exp[15]) begin
      n_fail++;
      $display("FAIL %s ctl=%b x=%h y=%h: res=%h zero=%b neg=%b, expected res=%h zero=%b neg=%b",
               tag, ctl, x, y, res, zero, neg, exp, exp == 16'h0, exp[15]);
    end
  endtask

  task automatic t_idle();
    apply(6'b000000, 16'h0000, 16'h0000);
    check("R4 idle AND of zeros", 16'h0000);
  endtask

  task automatic t_table();
    logic [15:0] ops [8] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000,
                             16'h0001, 16'h1234, 16'hA5C3, 16'h3C0F};
    for (int k = 0; k < 18; k++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          apply(CODES[k], ops[i], ops[j]);
          check("R8 listed setting", f_expect(k, ops[i], ops[j]));
        end
  endtask

  task automatic t_order();
    apply(6'b110000, 16'h1234, 16'h5A5A); check("R1 clear then invert x", 16'h5A5A);
    apply(6'b100010, 16'hBEEF, 16'h0042); check("R1 clear x only", 16'h0042);
    apply(6'b010010, 16'h0003, 16'h0010); check("R1 invert x only", 16'h000C);
    apply(6'b001100, 16'hC001, 16'h9999); check("R2 clear then invert y", 16'hC001);
    apply(6'b000110, 16'h0020, 16'hABCD); check("R2 invert y only", 16'h0020 + ~16'hABCD);
  endtask

  task automatic t_wrap();
    apply(6'b000010, 16'h7FFF, 16'h0001); check("R3 wrap to min", 16'h8000);
    apply(6'b000010, 16'hFFFF, 16'hFFFF); check("R3 carry dropped", 16'hFFFE);
    apply(6'b000010, 16'h8000, 16'h8000); check("R3 sum wraps to zero", 16'h0000);
  endtask

  task automatic t_post();
    apply(6'b000000, 16'hF0F0, 16'hFF00); check("R4 AND", 16'hF000);
    apply(6'b000001, 16'hF0F0, 16'hFF00); check("R5 inverted AND", 16'h0FFF);
  endtask

  task automatic t_flags();
    apply(6'b001100, 16'h8000, 16'h0000); check("R7 negative result", 16'h8000);
    apply(6'b001100, 16'h0000, 16'h1111); check("R6 zero result", 16'h0000);
    apply(6'b001101, 16'hFFFF, 16'h0000); check("R6 zero after inversion", 16'h0000);
    apply(6'b001101, 16'h7FFF, 16'h0000); check("R7 sign after inversion", 16'h8000);
  endtask

  task automatic t_unlisted();
    apply(6'b000011, 16'h0003, 16'h0004); check("R9 inverted sum", 16'hFFF8);
    apply(6'b100001, 16'h1357, 16'h2468); check("R9 cleared AND inverted", 16'hFFFF);
    apply(6'b000001, 16'h00FF, 16'h0F0F); check("R9 NAND", 16'hFFF0);
  endtask

  initial begin
    ctl = '0; x = '0; y = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_order();
    t_wrap();
    t_post();
    t_flags();
    t_unlisted();
    t_table();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule